// File: doc/BRIEF.md
# I2C Slave Receive Path with Selectable Clock Stretching

This block is the receive side of an I2C slave. It watches the bus through synchronised copies of SCL and SDA, finds START and STOP conditions, and checks the first byte of each transfer against its own 7-bit address and the general call address. After a match it shifts in data bytes MSB first and hands each completed byte to a host-side receive register that carries a full flag. It answers on SDA with an acknowledge bit and pulls SCL low whenever the host has not yet dealt with a byte, so no byte is ever overwritten before the host takes it.

Two configuration bits choose one of three stretching policies. In the plain policy, SCL is stretched only when the next byte would start while the receive register is still full. In the byte-wait policy, SCL is also stretched after every acknowledged data byte, and a host read releases it. In the pre-acknowledge policy, the flag goes up on the eighth rising edge and SCL is stretched from the eighth falling edge. The host then decides the acknowledge: writing the acknowledge value releases the bus, and a read does not. Both pins are open drain. The block sees each pin as an input and drives it only through a pull-low output.

States of the controller: `ST_IDLE` (waiting for START), `ST_ADDR` (shifting the address byte), `ST_ADDR_ACK` (driving ACK for a matched address), `ST_DATA` (shifting a data byte), `ST_PRE_ACK_HOLD` (stretch before the acknowledge bit), `ST_DATA_ACK` (driving the acknowledge bit of a data byte), `ST_POST_ACK_HOLD` (byte-wait stretch after the acknowledge), `ST_OVR_HOLD` (overrun stretch). The transitions are as follows:
- START leads from any state to `ST_ADDR`, and STOP leads from any state to `ST_IDLE`.
- From `ST_ADDR`, the eighth falling edge leads to `ST_ADDR_ACK` on a match and to `ST_IDLE` otherwise.
- From `ST_ADDR_ACK`, the ninth falling edge leads to `ST_OVR_HOLD` if the register is full and to `ST_DATA` otherwise.
- From `ST_DATA`, the eighth falling edge leads to `ST_PRE_ACK_HOLD` in pre-acknowledge mode and to `ST_DATA_ACK` otherwise.
- From `ST_PRE_ACK_HOLD`, an acknowledge write leads to `ST_DATA_ACK`.
- From `ST_DATA_ACK`, the ninth falling edge leads to `ST_IDLE` after a NACK. After an ACK it leads to `ST_POST_ACK_HOLD` in byte-wait mode, to `ST_OVR_HOLD` when the register is full, and to `ST_DATA` otherwise.
- A host read strobe takes `ST_POST_ACK_HOLD` or `ST_OVR_HOLD` back to `ST_DATA`.

Top module: `i2c_rx_stretch`

## Requirements
- R1: After reset both pull-low outputs are 0 and the receive full flag is 0.
- R2: An address byte is acknowledged (SDA pulled low during the ninth clock) only when its upper seven bits equal `own_addr_i` or are all zero and its last bit (R/W) is 0. Otherwise SDA is not pulled, and the later bytes of that transfer are neither stored nor acknowledged.
- R3: Data bits are taken MSB first on SCL rising edges. The byte appears in `rx_data_o` and `rx_full_o` rises with the eighth bit, not earlier. A one-cycle `rx_read_i` pulse clears the flag and leaves the data in place.
- R4: A pulse on `ack_wr_i` stores `ack_val_i` (0 means ACK, 1 means NACK). In the plain and byte-wait modes, that stored value is the acknowledge bit of each data byte: value 0 pulls SDA low for the ninth clock, and value 1 leaves SDA released.
- R5: When a data byte is acknowledged while the full flag is still set, SCL is pulled low from the ninth falling edge until a read strobe. The stored byte is not overwritten meanwhile.
- R6: After a STOP with the register still full, a new transfer that matches the address gets SCL pulled low from its address ninth falling edge until a read. A transfer to another address never sees SCL pulled.
- R7: With `cfg_byte_wait_i`=1 and `cfg_pre_ack_i`=0, SCL is pulled low from the ninth falling edge of every acknowledged data byte until a read strobe that comes after that edge, even if the host had already read the byte.
- R8: With `cfg_pre_ack_i`=1 (`cfg_byte_wait_i` then has no effect), SCL is pulled low from the eighth falling edge of each data byte. A read strobe does not release it. An `ack_wr_i` pulse releases it, and its `ack_val_i` becomes that byte's acknowledge bit.
- R9: The address byte never gets the byte-wait or pre-acknowledge stretch.
- R10: A STOP or a repeated START returns the block to address matching. Both keep `rx_data_o` and `rx_full_o` unchanged.
- R11: After a data byte is NACKed, in any mode, no stretch follows it. Later bytes of that transfer are ignored until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr_i | input | 7 | Slave address |
| cfg_byte_wait_i | input | 1 | Selects the byte-wait stretch |
| cfg_pre_ack_i | input | 1 | Selects the pre-acknowledge stretch |
| rx_data_o | output | 8 | Last received data byte |
| rx_full_o | output | 1 | Receive register holds an unread byte |
| rx_read_i | input | 1 | Host read strobe, one cycle |
| ack_val_i | input | 1 | Acknowledge value to store: 0 ACK, 1 NACK |
| ack_wr_i | input | 1 | Write strobe for the acknowledge value |

## Verification
The hardest case to reach is the stretch that follows a STOP. Reaching it needs a byte left unread across the end of one transfer, which is only possible when that byte was NACKed, since an acknowledged unread byte stretches the bus before any STOP can be sent. The bench therefore writes NACK before the last byte of one transfer, leaves the byte unread, and then opens two more transfers: one to the own address and one to a foreign address. In both, it watches for a stretch and checks that the stored byte is unchanged. A bus master model in the bench waits on the real SCL level, so every stretch must be released by the host action the mode names, or the run stops.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_PRE_ACK_HOLD,
        ST_DATA_ACK,
        ST_POST_ACK_HOLD,
        ST_OVR_HOLD
    } rx_state_e;

    typedef enum logic [1:0] {
        MODE_PLAIN,
        MODE_BYTE_WAIT,
        MODE_PRE_ACK
    } hold_mode_e;

    // Pre-acknowledge selection overrides byte-wait selection.
    function automatic hold_mode_e decode_mode(input logic byte_wait, input logic pre_ack);
        if (pre_ack)
            return MODE_PRE_ACK;
        else if (byte_wait)
            return MODE_BYTE_WAIT;
        else
            return MODE_PLAIN;
    endfunction

endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LINES   = 2;
    localparam int IDX_SCL = 0;
    localparam int IDX_SDA = 1;

    logic [LINES-1:0] pins;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev_q;

    assign pins = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain_q <= '1;
                else
                    chain_q <= {chain_q[STAGES-2:0], pins[g]};
            end
            assign synced[g] = chain_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= '1;
        else
            prev_q <= synced;
    end

    assign scl_s_o    = synced[IDX_SCL];
    assign sda_s_o    = synced[IDX_SDA];
    assign scl_rise_o =  synced[IDX_SCL] & ~prev_q[IDX_SCL];
    assign scl_fall_o = ~synced[IDX_SCL] &  prev_q[IDX_SCL];
    // SDA edges while SCL stays high are bus conditions.
    assign start_o = prev_q[IDX_SDA] & ~synced[IDX_SDA] & synced[IDX_SCL] & prev_q[IDX_SCL];
    assign stop_o  = ~prev_q[IDX_SDA] & synced[IDX_SDA] & synced[IDX_SCL] & prev_q[IDX_SCL];

endmodule

// File: rtl/i2c_rx_addr_cmp.sv
module i2c_rx_addr_cmp #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_i,
    output logic              match_o
);
    localparam int RW_BIT = 0;

    logic [ADDR_W-1:0] addr_field;
    logic              is_write;

    assign addr_field = byte_i[DATA_W-1 -: ADDR_W];
    assign is_write   = ~byte_i[RW_BIT];
    assign match_o    = is_write && ((addr_field == own_i) || (addr_field == '0));

endmodule

// File: rtl/i2c_rx_hold_reg.sv
module i2c_rx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o
);
    logic [DATA_W-1:0] data_q;
    logic              full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else if (load_i) begin
            data_q <= data_i;
            full_q <= 1'b1;
        end else if (rd_i) begin
            full_q <= 1'b0;
        end
    end

    assign data_o = data_q;
    assign full_o = full_q;

    // R5: the stretch logic must never deliver a byte into a full register
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !full_q);

    // R3: a delivered byte raises the flag
    p_load_sets_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> full_q);

    // R3: a read clears the flag and keeps the data
    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !load_i) |=> (!full_q && $stable(data_q)));

endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
    import i2c_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s_i,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              addr_match_i,
    input  hold_mode_e        mode_i,
    input  logic              full_i,
    input  logic              rd_strobe_i,
    input  logic              ack_wr_i,
    input  logic              ack_val_i,
    output logic [DATA_W-1:0] shift_o,
    output logic              load_o,
    output logic [DATA_W-1:0] load_data_o,
    output logic              scl_pull_o,
    output logic              sda_pull_o
);
    localparam int              CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] PENULT  = CNT_W'(DATA_W - 1);

    rx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ack_q;        // stored acknowledge value, 0 = ACK
    logic              drive_ack_q;  // 1 = pull SDA in the current data ack slot
    logic              last_edge;
    logic              take_bit;

    assign last_edge = scl_fall_i && (cnt_q == LAST);
    assign take_bit  = scl_rise_i && (cnt_q != LAST) &&
                       ((state_q == ST_ADDR) || (state_q == ST_DATA));

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_ADDR;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR:
                    if (last_edge)
                        state_d = addr_match_i ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:
                    if (scl_fall_i)
                        state_d = full_i ? ST_OVR_HOLD : ST_DATA;
                ST_DATA:
                    if (last_edge)
                        state_d = (mode_i == MODE_PRE_ACK) ? ST_PRE_ACK_HOLD : ST_DATA_ACK;
                ST_PRE_ACK_HOLD:
                    if (ack_wr_i)
                        state_d = ST_DATA_ACK;
                ST_DATA_ACK:
                    if (scl_fall_i) begin
                        if (!drive_ack_q)
                            state_d = ST_IDLE;
                        else if (mode_i == MODE_BYTE_WAIT)
                            state_d = ST_POST_ACK_HOLD;
                        else if (full_i)
                            state_d = ST_OVR_HOLD;
                        else
                            state_d = ST_DATA;
                    end
                ST_POST_ACK_HOLD:
                    if (rd_strobe_i)
                        state_d = ST_DATA;
                ST_OVR_HOLD:
                    if (rd_strobe_i || !full_i)
                        state_d = ST_DATA;
                default:
                    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // shifter, bit counter, acknowledge latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            cnt_q       <= '0;
            ack_q       <= 1'b0;
            drive_ack_q <= 1'b0;
        end else begin
            if (start_i || (state_d == ST_DATA && state_q != ST_DATA)) begin
                cnt_q <= '0;
            end else if (take_bit) begin
                shreg_q <= {shreg_q[DATA_W-2:0], sda_s_i};
                cnt_q   <= cnt_q + CNT_W'(1);
            end
            if (ack_wr_i)
                ack_q <= ack_val_i;
            if (state_d == ST_DATA_ACK && state_q != ST_DATA_ACK)
                drive_ack_q <= ack_wr_i ? ~ack_val_i : ~ack_q;
        end
    end

    // outputs
    always_comb begin
        scl_pull_o  = 1'b0;
        sda_pull_o  = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK:      sda_pull_o = 1'b1;
            ST_DATA_ACK:      sda_pull_o = drive_ack_q;
            ST_PRE_ACK_HOLD,
            ST_POST_ACK_HOLD,
            ST_OVR_HOLD:      scl_pull_o = 1'b1;
            default: ;
        endcase
    end

    assign shift_o     = shreg_q;
    assign load_o      = (state_q == ST_DATA) && scl_rise_i && (cnt_q == PENULT);
    assign load_data_o = {shreg_q[DATA_W-2:0], sda_s_i};

    // R4: SDA is only changed while SCL is low
    p_sda_change_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_s_i);

    // R8: a read strobe alone never ends the pre-acknowledge stretch
    p_read_keeps_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE_ACK_HOLD && rd_strobe_i && !ack_wr_i && !start_i && !stop_i)
            |=> scl_pull_o);

    // R9: the address acknowledge never leads into a per-byte stretch
    p_addr_no_byte_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK && scl_fall_i)
            |=> (state_q != ST_POST_ACK_HOLD && state_q != ST_PRE_ACK_HOLD));

    // R11: a NACKed byte is never followed by a stretch
    p_nack_no_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA_ACK && !sda_pull_o && scl_fall_i && !start_i) |=> !scl_pull_o);

endmodule

// File: rtl/i2c_rx_stretch.sv
module i2c_rx_stretch
    import i2c_rx_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull_o,
    output logic              sda_pull_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              cfg_byte_wait_i,
    input  logic              cfg_pre_ack_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_full_o,
    input  logic              rx_read_i,
    input  logic              ack_val_i,
    input  logic              ack_wr_i
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [DATA_W-1:0] shift_val;
    logic [DATA_W-1:0] load_data;
    logic              load;
    logic              addr_match;
    hold_mode_e        mode;

    assign mode = decode_mode(cfg_byte_wait_i, cfg_pre_ack_i);

    i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s_o    (scl_s),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_rx_addr_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .byte_i  (shift_val),
        .own_i   (own_addr_i),
        .match_o (addr_match)
    );

    i2c_rx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_s_i      (scl_s),
        .sda_s_i      (sda_s),
        .scl_rise_i   (scl_rise),
        .scl_fall_i   (scl_fall),
        .start_i      (start_det),
        .stop_i       (stop_det),
        .addr_match_i (addr_match),
        .mode_i       (mode),
        .full_i       (rx_full_o),
        .rd_strobe_i  (rx_read_i),
        .ack_wr_i     (ack_wr_i),
        .ack_val_i    (ack_val_i),
        .shift_o      (shift_val),
        .load_o       (load),
        .load_data_o  (load_data),
        .scl_pull_o   (scl_pull_o),
        .sda_pull_o   (sda_pull_o)
    );

    i2c_rx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .data_i (load_data),
        .rd_i   (rx_read_i),
        .data_o (rx_data_o),
        .full_o (rx_full_o)
    );

    // R1: nothing is pulled in the cycle after reset ends
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!scl_pull_o && !sda_pull_o && !rx_full_o));

endmodule

// File: tb/i2c_rx_stretch_tb.sv
module i2c_rx_stretch_tb;
    localparam int         CLK_PERIOD = 10;
    localparam int         THALF      = 10;
    localparam logic [6:0] OWN        = 7'h2C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_line, sda_line;
    logic scl_pull, sda_pull;
    logic cfg_wait = 1'b0, cfg_pre = 1'b0;
    logic [7:0] rx_data;
    logic rx_full;
    logic rx_read = 1'b0, ack_val = 1'b0, ack_wr = 1'b0;

    int total = 0;
    int failed = 0;
    int hold_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = m_scl & ~scl_pull;
    assign sda_line = m_sda & ~sda_pull;

    always @(posedge clk) if (scl_pull) hold_cnt <= hold_cnt + 1;

    i2c_rx_stretch u_dut (
        .clk (clk), .rst_n (rst_n),
        .scl_i (scl_line), .sda_i (sda_line),
        .scl_pull_o (scl_pull), .sda_pull_o (sda_pull),
        .own_addr_i (OWN),
        .cfg_byte_wait_i (cfg_wait), .cfg_pre_ack_i (cfg_pre),
        .rx_data_o (rx_data), .rx_full_o (rx_full), .rx_read_i (rx_read),
        .ack_val_i (ack_val), .ack_wr_i (ack_wr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; idle(THALF);
        m_scl = 1'b1; wait_scl_high(); idle(THALF);
        m_sda = 1'b0; idle(THALF);
        m_scl = 1'b0; idle(THALF);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; idle(THALF);
        m_scl = 1'b1; wait_scl_high(); idle(THALF);
        m_sda = 1'b1; idle(THALF);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; idle(THALF);
        m_scl = 1'b1; wait_scl_high(); idle(THALF);
        m_scl = 1'b0; idle(THALF);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[7-i]);
    endtask

    // ninth clock; returns the SDA level seen while SCL is high
    task automatic ack_clock(output logic s);
        m_sda = 1'b1; idle(THALF);
        m_scl = 1'b1; wait_scl_high(); idle(THALF/2);
        s = sda_line; idle(THALF/2);
        m_scl = 1'b0; idle(THALF);
    endtask

    task automatic host_read();
        @(negedge clk) rx_read = 1'b1;
        @(negedge clk) rx_read = 1'b0;
        idle(2);
    endtask

    task automatic host_ack(input logic v);
        @(negedge clk) begin ack_wr = 1'b1; ack_val = v; end
        @(negedge clk) ack_wr = 1'b0;
        idle(2);
    endtask

    // address phase with ACK expected
    task automatic addr_own(input string req);
        logic s;
        bus_start();
        send_bits({OWN, 1'b0}, 8);
        ack_clock(s);
        chk(req, "own address ack", s, 0);
    endtask

    initial begin
        logic s;
        logic [7:0] d;
        int snap;
        int ackv;
        idle(5);
        rst_n = 1'b1;
        idle(3);
        // R1
        chk("R1", "scl_pull after reset", scl_pull, 0);
        chk("R1", "sda_pull after reset", sda_pull, 0);
        chk("R1", "full after reset", rx_full, 0);

        // R2 / R3 / R4: sweep every 7-bit address, plain mode
        for (int a = 0; a < 128; a++) begin
            bit hit;
            hit = (a == int'(OWN)) || (a == 0);
            snap = hold_cnt;
            bus_start();
            send_bits({a[6:0], 1'b0}, 8);
            ack_clock(s);
            chk("R2", $sformatf("address %0h ack level", a), s, hit ? 0 : 1);
            if (hit) begin
                d = 8'((a * 37 + 11) & 8'hFF);
                send_bits(d, 7);
                chk("R3", "full before eighth bit", rx_full, 0);
                send_bit(d[0]);
                chk("R3", "full after eighth bit", rx_full, 1);
                chk("R3", "data MSB first", rx_data, d);
                host_read();
                chk("R3", "read clears full", rx_full, 0);
                chk("R3", "read keeps data", rx_data, d);
                ack_clock(s);
                chk("R4", "stored ACK drives SDA low", s, 0);
            end else if (a % 16 == 5) begin
                send_bits(8'hC3, 8);
                ack_clock(s);
                chk("R2", "byte after mismatch not acked", s, 1);
                chk("R2", "byte after mismatch not stored", rx_full, 0);
            end
            bus_stop();
            chk("R4", "no stretch with register emptied", hold_cnt - snap, 0);
        end
        // R2: own address with R/W=1 is not acked
        bus_start();
        send_bits({OWN, 1'b1}, 8);
        ack_clock(s);
        chk("R2", "read-direction address not acked", s, 1);
        bus_stop();

        // per-mode sweep: 0 plain, 1 byte-wait, 2 pre-ack
        for (int m = 0; m < 3; m++) begin
            cfg_wait = (m == 1);
            cfg_pre  = (m == 2);
            host_ack(1'b0);
            addr_own("R9");
            chk("R9", "no stretch after address", scl_pull, 0);
            for (int k = 0; k < 8; k++) begin
                d = 8'((k * 8'h25) ^ (m * 8'h5A) ^ 8'h81);
                ackv = (k == 7) ? 1 : 0;
                if (m == 2) cfg_wait = (k >= 4);
                if (m != 2) host_ack(ackv[0]);
                send_bits(d, 8);
                chk("R3", "data per mode", rx_data, d);
                chk("R3", "full per mode", rx_full, 1);
                if (m == 2) begin
                    chk("R8", "stretch after eighth fall", scl_pull, 1);
                    host_read();
                    idle(6);
                    chk("R8", "read does not release", scl_pull, 1);
                    chk("R8", "read still clears full", rx_full, 0);
                    host_ack(ackv[0]);
                    chk("R8", "ack write releases", scl_pull, 0);
                    ack_clock(s);
                    chk("R8", "written value is ack bit", s, ackv);
                    chk("R8", "no stretch after ack (wait ignored)", scl_pull, 0);
                end else begin
                    chk("R4", "no stretch before ack", scl_pull, 0);
                    host_read();
                    ack_clock(s);
                    chk("R4", "stored value is ack bit", s, ackv);
                    if (m == 1 && k != 7) begin
                        chk("R7", "stretch after ninth fall despite read", scl_pull, 1);
                        idle(8);
                        chk("R7", "stretch persists", scl_pull, 1);
                        host_read();
                        chk("R7", "read releases", scl_pull, 0);
                    end else begin
                        chk("R11", "no stretch after ack slot", scl_pull, 0);
                    end
                end
            end
            bus_stop();
        end
        cfg_wait = 1'b0;
        cfg_pre  = 1'b0;
        host_ack(1'b0);

        // R5: overrun stretch inside a transfer
        addr_own("R5");
        send_bits(8'hA5, 8);
        ack_clock(s);
        chk("R5", "acked byte", s, 0);
        chk("R5", "overrun stretch", scl_pull, 1);
        idle(20);
        chk("R5", "stretch holds", scl_pull, 1);
        chk("R5", "data not overwritten", rx_data, 8'hA5);
        host_read();
        chk("R5", "read releases", scl_pull, 0);
        send_bits(8'h3C, 8);
        chk("R5", "next byte stored", rx_data, 8'h3C);
        host_read();
        ack_clock(s);
        bus_stop();

        // R11 and R6 / R10: unread byte across STOP
        addr_own("R6");
        host_ack(1'b1);
        send_bits(8'h96, 8);
        ack_clock(s);
        chk("R11", "NACK on SDA", s, 1);
        chk("R11", "no stretch after NACK", scl_pull, 0);
        send_bits(8'h11, 8);
        ack_clock(s);
        chk("R11", "later byte ignored", rx_data, 8'h96);
        chk("R11", "later byte not acked", s, 1);
        bus_stop();
        chk("R10", "STOP keeps full", rx_full, 1);
        chk("R10", "STOP keeps data", rx_data, 8'h96);
        host_ack(1'b0);
        addr_own("R6");
        chk("R6", "stretch after matched address", scl_pull, 1);
        chk("R6", "data kept", rx_data, 8'h96);
        host_read();
        chk("R6", "read releases address stretch", scl_pull, 0);
        host_ack(1'b1);
        send_bits(8'h5E, 8);
        ack_clock(s);
        bus_stop();
        snap = hold_cnt;
        bus_start();
        send_bits({OWN ^ 7'h01, 1'b0}, 8);
        ack_clock(s);
        chk("R6", "foreign address not acked", s, 1);
        send_bits(8'hF0, 8);
        ack_clock(s);
        bus_stop();
        chk("R6", "foreign transfer never stretched", hold_cnt - snap, 0);
        chk("R6", "register untouched", rx_data, 8'h5E);
        chk("R6", "flag untouched", rx_full, 1);

        // R10: repeated START mid-byte
        host_ack(1'b0);
        addr_own("R10");
        host_read();
        send_bits(8'hE0, 3);
        addr_own("R10");
        chk("R10", "repeated START keeps data", rx_data, 8'h5E);
        chk("R10", "repeated START keeps flag", rx_full, 0);
        send_bits(8'h4B, 8);
        chk("R10", "byte after repeated START", rx_data, 8'h4B);
        host_read();
        ack_clock(s);
        bus_stop();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule